// File: doc/BRIEF.md
# Logical Device Activation and I/O Range Check

This block holds the control state of one logical device on a card that is configured through a byte-wide register port. It keeps an activation bit, a two-bit range-check control, and a bank of 16-bit I/O base addresses that are written one byte at a time. A card controller writes and reads these registers through the configuration port. A separate I/O read port presents a bus address and gets back a claim flag and a data byte.

Each base address defines a window of `RANGE_LEN` consecutive ports. A base of zero means the range is unused. While the device is active, it claims reads that fall inside any programmed window. The data returned on a claimed read is zero, because the device's own function registers are outside this block. While the device is inactive and the range check is enabled, it answers reads in its windows with a fixed test byte. Software can then detect another agent decoding the same ports. Writing 1 to the activation bit also turns the range check off.

All register writes take effect on the clock edge after they are presented. Register reads and I/O responses are combinational from the stored state.

Top module: `ldev_decode`

## Requirements
- R1: After reset, every register reads 0x00 and no I/O read is claimed.
- R2: Configuration address 0x30 holds the activation bit in bit 0. Bits 7:1 always read as zero, whatever was written.
- R3: Configuration address 0x31 holds the check pattern select in bit 0 and the check enable in bit 1. Bits 7:2 always read as zero.
- R4: Range i has its base bits 15:8 at address 0x60+2i and its base bits 7:0 at address 0x61+2i. Each byte reads back what was last written to it.
- R5: While active, an I/O read at an address a with base <= a < base+RANGE_LEN, for some range whose base is non-zero, is claimed and returns 0x00.
- R6: A range whose base is zero never matches. Addresses outside every window are never claimed.
- R7: While inactive with the check enable set, a read inside a window is claimed. It returns 0x55 when the pattern select is 1 and 0xAA when it is 0.
- R8: While inactive with the check enable clear, no I/O read is claimed.
- R9: A write of 1 to bit 0 of 0x30 clears the check enable. The pattern select is kept.
- R10: The configuration reset command clears the activation, the range-check register and every base to zero. It takes priority over a write in the same cycle.
- R11: When the I/O read strobe is low, nothing is claimed and the data output is 0x00.
- R12: A configuration read at any address other than 0x30, 0x31 or a base byte returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_reset | input | 1 | Configuration reset command pulse |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | 16 | I/O read address |
| io_rdata | output | 8 | I/O read data |
| io_claim | output | 1 | High when the block answers the I/O read |

## Verification
The hardest state to reach is the window edge under each answering mode. It needs every base programmed byte by byte to a distinct value, and then the device moved through the inactive-unchecked, checked-0x55, checked-0xAA and active states. The stimulus reaches it by rewriting the control registers between full sweeps. Each sweep runs from two ports below to two ports past every window, and the expected claim is computed from the programmed bases. The bench also steers into the case where activation and the check enable meet: it activates while the check is on, then reads 0x31 back. It also issues a reset command in the same cycle as an activation write.

// File: rtl/ldev_pkg.sv
// Package: shared register addresses, test bytes and the range-check
// register layout for the logical device decode block.
package ldev_pkg;
    localparam logic [7:0] REG_ACT   = 8'h30;
    localparam logic [7:0] REG_RCHK  = 8'h31;
    localparam logic [7:0] REG_BASE0 = 8'h60;
    localparam logic [7:0] PAT_SEL1  = 8'h55;
    localparam logic [7:0] PAT_SEL0  = 8'hAA;

    typedef struct packed {
        logic en;     // bit 1: check enable
        logic sel55;  // bit 0: pattern select
    } rchk_t;
endpackage

// File: rtl/ldev_ctrl_regs.sv
// Module: activation and range-check control registers.
// Assumes: writes are single-cycle strobes, and the configuration reset
// command outranks any write presented in the same cycle.
module ldev_ctrl_regs
    import ldev_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_reset,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_addr,
    input  logic [1:0] wbits,
    output logic       active,
    output rchk_t      rchk
);
    // Update the activation bit and check control; activation clears the check enable.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_reset) begin
            active <= 1'b0;
            rchk   <= '0;
        end else if (cfg_wr) begin
            if (cfg_addr == REG_ACT) begin
                active <= wbits[0];
                if (wbits[0]) rchk.en <= 1'b0;
            end else if (cfg_addr == REG_RCHK) begin
                rchk <= rchk_t'(wbits);
            end
        end
    end
endmodule

// File: rtl/ldev_base_bank.sv
// Module: bank of NUM_RANGES 16-bit I/O base registers, byte-written.
// Assumes: range i occupies the high byte at REG_BASE0+2i and the low
// byte at REG_BASE0+2i+1, and all bytes fit below address 0x100.
module ldev_base_bank
    import ldev_pkg::*;
#(
    parameter int NUM_RANGES = 8,
    parameter int AW         = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_reset,
    input  logic                           cfg_wr,
    input  logic [7:0]                     cfg_addr,
    input  logic [7:0]                     cfg_wdata,
    output logic [NUM_RANGES-1:0][AW-1:0]  bases,
    output logic                           rd_hit,
    output logic [7:0]                     rd_data
);
    localparam int BYTES_PER = AW / 8;

    for (genvar i = 0; i < NUM_RANGES; i++) begin : g_rng
        localparam logic [7:0] HI_A = REG_BASE0 + 8'(2 * i);
        localparam logic [7:0] LO_A = HI_A + 8'd1;
        // Capture the high or low byte of range i on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n || cfg_reset) begin
                bases[i] <= '0;
            end else if (cfg_wr && cfg_addr == HI_A) begin
                bases[i][AW-1:8] <= cfg_wdata[AW-9:0];
            end else if (cfg_wr && cfg_addr == LO_A) begin
                bases[i][7:0] <= cfg_wdata;
            end
        end
    end

    // Return the addressed base byte, flagging a hit on a mapped address.
    always_comb begin
        rd_hit  = 1'b0;
        rd_data = '0;
        for (int i = 0; i < NUM_RANGES; i++) begin
            if (cfg_addr == REG_BASE0 + 8'(BYTES_PER * i)) begin
                rd_hit  = 1'b1;
                rd_data = 8'(bases[i][AW-1:8]);
            end else if (cfg_addr == REG_BASE0 + 8'(BYTES_PER * i + 1)) begin
                rd_hit  = 1'b1;
                rd_data = bases[i][7:0];
            end
        end
    end
endmodule

// File: rtl/ldev_range_match.sv
// Module: parallel window compare of one I/O address against every base.
// Assumes: a zero base disables its window; the window end is computed
// one bit wider so a base near the top of the space does not wrap.
module ldev_range_match #(
    parameter int NUM_RANGES = 8,
    parameter int RANGE_LEN  = 8,
    parameter int AW         = 16
) (
    input  logic [NUM_RANGES-1:0][AW-1:0] bases,
    input  logic [AW-1:0]                 addr,
    output logic                          any_hit
);
    localparam logic [AW:0] LEN_EXT = (AW + 1)'(RANGE_LEN);

    logic [NUM_RANGES-1:0] hit;

    for (genvar i = 0; i < NUM_RANGES; i++) begin : g_cmp
        // Decide whether addr falls in the window of range i.
        always_comb begin
            hit[i] = (bases[i] != '0)
                  && (addr >= bases[i])
                  && ({1'b0, addr} < ({1'b0, bases[i]} + LEN_EXT));
        end
    end

    // Merge the per-range results.
    always_comb any_hit = |hit;
endmodule

// File: rtl/ldev_decode.sv
// Module: top of the logical device activation and range-check block.
// Assumes: configuration reads and I/O responses are combinational from
// stored state; an active device returns 0x00 as data placeholder.
module ldev_decode
    import ldev_pkg::*;
#(
    parameter int NUM_RANGES = 8,
    parameter int RANGE_LEN  = 8,
    parameter int AW         = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_reset,
    input  logic          cfg_wr,
    input  logic [7:0]    cfg_addr,
    input  logic [7:0]    cfg_wdata,
    output logic [7:0]    cfg_rdata,
    input  logic          io_rd,
    input  logic [AW-1:0] io_addr,
    output logic [7:0]    io_rdata,
    output logic          io_claim
);
    logic                          active_q;
    rchk_t                         rchk_q;
    logic                          chk_en;
    logic [NUM_RANGES-1:0][AW-1:0] bases;
    logic                          base_hit;
    logic [7:0]                    base_data;
    logic                          win_hit;

    ldev_ctrl_regs u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_reset (cfg_reset),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .wbits     (cfg_wdata[1:0]),
        .active    (active_q),
        .rchk      (rchk_q)
    );

    ldev_base_bank #(.NUM_RANGES(NUM_RANGES), .AW(AW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_reset (cfg_reset),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .bases     (bases),
        .rd_hit    (base_hit),
        .rd_data   (base_data)
    );

    ldev_range_match #(.NUM_RANGES(NUM_RANGES), .RANGE_LEN(RANGE_LEN), .AW(AW)) u_match (
        .bases   (bases),
        .addr    (io_addr),
        .any_hit (win_hit)
    );

    // Expose the check enable as a plain signal for the checker.
    always_comb chk_en = rchk_q.en;

    // Select configuration read data by address.
    always_comb begin
        if (cfg_addr == REG_ACT)       cfg_rdata = {7'b0, active_q};
        else if (cfg_addr == REG_RCHK) cfg_rdata = {6'b0, rchk_q};
        else if (base_hit)             cfg_rdata = base_data;
        else                           cfg_rdata = 8'h00;
    end

    // Decide the I/O claim and choose the test byte while inactive.
    always_comb begin
        io_claim = io_rd && win_hit && (active_q || rchk_q.en);
        if (io_claim && !active_q) io_rdata = rchk_q.sel55 ? PAT_SEL1 : PAT_SEL0;
        else                       io_rdata = 8'h00;
    end
endmodule

// File: rtl/ldev_decode_chk.sv
// Module: property checker for ldev_decode, attached through bind.
// Assumes: it sees the ports plus the stored activation and check enable.
module ldev_decode_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_reset,
    input logic       cfg_wr,
    input logic [7:0] cfg_addr,
    input logic [7:0] cfg_wdata,
    input logic [7:0] cfg_rdata,
    input logic       io_rd,
    input logic [7:0] io_rdata,
    input logic       io_claim,
    input logic       active,
    input logic       rchk_en
);
    a_r11_idle_no_claim: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |-> (!io_claim && io_rdata == 8'h00));

    a_r5_active_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        (io_claim && active) |-> io_rdata == 8'h00);

    a_r7_check_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        (io_claim && !active) |-> (rchk_en && (io_rdata == 8'h55 || io_rdata == 8'hAA)));

    a_r9_activate_drops_check: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr == 8'h30 && cfg_wdata[0] && !cfg_reset) |=> (active && !rchk_en));

    a_r10_reset_cmd_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_reset |=> (!active && !rchk_en));

    a_r2_act_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == 8'h30) |-> cfg_rdata[7:1] == 7'd0);

    a_r3_rchk_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == 8'h31) |-> cfg_rdata[7:2] == 6'd0);
endmodule

bind ldev_decode ldev_decode_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_reset (cfg_reset),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .io_rd     (io_rd),
    .io_rdata  (io_rdata),
    .io_claim  (io_claim),
    .active    (active_q),
    .rchk_en   (chk_en)
);

// File: tb/sim_ldev_decode.sv
// Bench: sweeps all configuration addresses and every window edge,
// predicting results from a register model written from the requirements.
module sim_ldev_decode;
    localparam int NR  = 8;
    localparam int LEN = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_reset = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        io_rd = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_rdata;
    logic        io_claim;

    int checks = 0;
    int errors = 0;

    // Bench model of stored state.
    logic        m_act = 1'b0;
    logic [1:0]  m_rc = '0;
    logic [15:0] m_base [NR];

    always #4 clk = ~clk;

    ldev_decode #(.NUM_RANGES(NR), .RANGE_LEN(LEN), .AW(16)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_reset(cfg_reset), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .io_rd(io_rd), .io_addr(io_addr), .io_rdata(io_rdata), .io_claim(io_claim)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_cfg(int a);
        if (a == 'h30) return {7'b0, m_act};
        if (a == 'h31) return {6'b0, m_rc};
        if (a >= 'h60 && a < 'h60 + 2 * NR)
            return ((a - 'h60) % 2 == 0) ? m_base[(a - 'h60) / 2][15:8]
                                         : m_base[(a - 'h60) / 2][7:0];
        return 8'h00;
    endfunction

    function automatic bit exp_hit(int a);
        for (int i = 0; i < NR; i++)
            if (m_base[i] != 0 && a >= int'(m_base[i]) && a < int'(m_base[i]) + LEN) return 1'b1;
        return 1'b0;
    endfunction

    task automatic cfg_write(int a, int d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 8'(a); cfg_wdata = 8'(d);
        @(negedge clk);
        cfg_wr = 1'b0;
        if (a == 'h30) begin m_act = d[0]; if (d[0]) m_rc[1] = 1'b0; end
        else if (a == 'h31) m_rc = d[1:0];
        else if (a >= 'h60 && a < 'h60 + 2 * NR) begin
            if ((a - 'h60) % 2 == 0) m_base[(a - 'h60) / 2][15:8] = 8'(d);
            else                     m_base[(a - 'h60) / 2][7:0]  = 8'(d);
        end
    endtask

    task automatic cfg_sweep(string req);
        for (int a = 0; a < 256; a++) begin
            cfg_addr = 8'(a);
            #1;
            check(req, cfg_rdata, exp_cfg(a));
        end
    endtask

    task automatic io_probe(string req, int a);
        bit          h;
        bit          c;
        logic [7:0]  d;
        h = exp_hit(a);
        c = h && (m_act || m_rc[1]);
        d = (c && !m_act) ? (m_rc[0] ? 8'h55 : 8'hAA) : 8'h00;
        io_rd = 1'b1; io_addr = 16'(a);
        #1;
        check(req, io_claim, c);
        check(req, io_rdata, d);
        io_rd = 1'b0;
        #1;
    endtask

    task automatic io_sweep(string req);
        for (int i = 0; i < NR; i++)
            for (int a = int'(m_base[i]) - 2; a < int'(m_base[i]) + LEN + 2; a++)
                if (a >= 0) io_probe(req, a);
        for (int a = 0; a < LEN + 2; a++) io_probe(req, a);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NR; i++) m_base[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 and R12: everything reads zero after reset.
        cfg_sweep("R1");
        io_probe("R1", 0); io_probe("R1", 'h200);

        // R2, R3: upper bits read zero.
        cfg_write('h31, 'hFF); cfg_addr = 8'h31; #1; check("R3", cfg_rdata, 8'h03);
        cfg_write('h31, 'h00);
        cfg_write('h30, 'hFE); cfg_addr = 8'h30; #1; check("R2", cfg_rdata, 8'h00);

        // R4: bytes per range; range NR-1 left at zero for R6.
        for (int i = 0; i < NR - 1; i++) begin
            cfg_write('h60 + 2 * i, 2 + i);
            cfg_write('h61 + 2 * i, 'h10 + 'h23 * i);
        end
        cfg_sweep("R4");
        cfg_sweep("R12");

        // R8: inactive, check off.
        io_sweep("R8");

        // R7: check on, both patterns.
        cfg_write('h31, 'h03); io_sweep("R7");
        cfg_write('h31, 'h02); io_sweep("R7");

        // R9: activation clears the check enable, keeps the select.
        cfg_write('h31, 'h03);
        cfg_write('h30, 'h01);
        cfg_addr = 8'h31; #1; check("R9", cfg_rdata, 8'h01);

        // R5 and R6: active claims windows only.
        io_sweep("R5");
        io_sweep("R6");

        // R11: strobe low means no claim.
        io_rd = 1'b0; io_addr = m_base[0];
        #1; check("R11", io_claim, 0); check("R11", io_rdata, 0);

        // R10: reset command beats a same-cycle write.
        cfg_write('h31, 'h03);
        @(negedge clk);
        cfg_reset = 1'b1; cfg_wr = 1'b1; cfg_addr = 8'h30; cfg_wdata = 8'h01;
        @(negedge clk);
        cfg_reset = 1'b0; cfg_wr = 1'b0;
        m_act = 1'b0; m_rc = '0;
        for (int i = 0; i < NR; i++) m_base[i] = '0;
        cfg_sweep("R10");
        io_probe("R10", 'h200);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule